// File: doc/BRIEF.md
# Coherency-Unit Control and Status Registers

This block is the register file of the snoop control unit in a small multiprocessor cluster. A simple register bus reaches it with a request strobe, a write flag, a byte address, 32-bit write data and a transfer size given as a byte count. Reads answer one cycle after the request, together with a read-valid strobe.

The block holds three pieces of state. The first is a one-bit unit enable. The second is a read-only configuration word built from the core-count parameter. The third is a 32-bit power status word with one byte per core, which accepts byte, halfword and word writes at any of its four byte addresses. Every other offset is a hole that reads as zero and ignores writes. That includes the invalidate-all, address-filter and access-control locations.

Top module: `coh_ctrl_regs`

## Requirements
- R1: While reset is high, and on the cycle after it falls, the read-valid strobe is low. Reset clears both the enable bit and the power status word to zero.
- R2: A write to offset 0x00 stores write-data bit 0 as the enable bit. A read of 0x00 returns that bit in bit 0 and zero in bits 31:1.
- R3: A read of offset 0x04 returns N-1 in bits 1:0 and N ones starting at bit 4, where N is the core-count parameter (1 to 4). Writes to 0x04 change nothing.
- R4: A write at offset 0x08+k, with k from 0 to 3 and size s in bytes, replaces power-status byte lanes k up to k+s-1 with write-data bytes 0 up to s-1, in that order. All other lanes keep their values.
- R5: When k+s exceeds 4, only the lanes up to lane 3 (bit 31) are written, and the remaining write-data bytes are dropped.
- R6: A read at offset 0x08+k returns the power status word shifted right by 8*k bits, with zeros filling the top.
- R7: Reads of 0x0C, 0x40, 0x44, 0x50, 0x54 and every other offset not named in R2 to R6 return zero. Writes to them change no state.
- R8: The size field carries a byte count, and only the values 1, 2 and 4 are legal. A write of any other size changes no state.
- R9: A read request is answered on the next cycle with read-valid high and the data registered. A cycle with no read request yields read-valid low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Transfer request strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset inside the block |
| bus_size | input | 3 | Transfer size in bytes (1, 2 or 4 legal) |
| bus_wdata | input | 32 | Write data, byte 0 in bits 7:0 |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |

## Verification
The hardest case to reach is a sub-word write at an odd lane offset that runs past bit 31. Proving it requires both that clipping occurs and that the lanes below the offset survive. To reach it, the stimulus first fills the power word with distinct byte values using a full word write. It then issues halfword and word writes at offsets 0x0A and 0x0B, and reads the word back at several lane offsets, so that each byte is seen in a different bit position. Holes and illegal sizes are followed by read-backs of the enable and power state. A write that leaked into those registers would therefore show at the ports.

// File: rtl/coh_regs_pkg.sv
package coh_regs_pkg;

  typedef enum logic [1:0] {
    RGN_CTL  = 2'd0,
    RGN_CFG  = 2'd1,
    RGN_PWR  = 2'd2,
    RGN_HOLE = 2'd3
  } region_t;

  localparam int unsigned OFS_CTL     = 'h00;
  localparam int unsigned OFS_CFG     = 'h04;
  localparam int unsigned OFS_PWR_BASE = 'h08;

  // legal transfer sizes are byte counts 1, 2, 4
  function automatic logic size_legal(input logic [2:0] sz);
    return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
  endfunction

  // lanes touched by a transfer of the given size starting at lane 0
  function automatic logic [3:0] size_lanes(input logic [2:0] sz);
    case (sz)
      3'd1:    return 4'b0001;
      3'd2:    return 4'b0011;
      3'd4:    return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [31:0] cfg_word(input int unsigned ncores);
    logic [31:0] w;
    w = '0;
    for (int i = 0; i < 4; i++) begin
      if (i < int'(ncores)) w[4+i] = 1'b1;
    end
    w[1:0] = 2'(ncores - 1);
    return w;
  endfunction

endpackage

// File: rtl/coh_addr_decode.sv
module coh_addr_decode
  import coh_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output region_t           region,
  output logic [1:0]        lane
);

  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFS_CTL);
  localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(OFS_CFG);
  localparam logic [ADDR_W-3:0] A_PWR_W = (ADDR_W-2)'(OFS_PWR_BASE >> 2);

  always_comb begin
    lane = addr[1:0];
    if (addr == A_CTL)                    region = RGN_CTL;
    else if (addr == A_CFG)               region = RGN_CFG;
    else if (addr[ADDR_W-1:2] == A_PWR_W) region = RGN_PWR;
    else                                  region = RGN_HOLE;
  end

endmodule

// File: rtl/coh_pwr_bank.sv
module coh_pwr_bank
  import coh_regs_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [1:0]         lane,
  input  logic [2:0]         size,
  input  logic [8*LANES-1:0] wdata,
  output logic [8*LANES-1:0] status
);

  localparam int unsigned W = 8 * LANES;

  logic [LANES-1:0] lane_en;
  logic [W-1:0]     wdata_sh;

  // shifting to the start lane drops bytes past the top lane (clipping)
  always_comb begin
    lane_en  = LANES'(size_lanes(size) << lane);
    wdata_sh = wdata << (8 * lane);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)                      status[8*g +: 8] <= 8'h00;
      else if (wr_en && lane_en[g]) status[8*g +: 8] <= wdata_sh[8*g +: 8];
    end
  end

endmodule

// File: rtl/coh_rd_mux.sv
module coh_rd_mux
  import coh_regs_pkg::*;
#(
  parameter int unsigned NUM_CORES = 1
) (
  input  region_t     region,
  input  logic [1:0]  lane,
  input  logic        ctl,
  input  logic [31:0] pwr,
  output logic [31:0] word
);

  localparam logic [31:0] CFG = cfg_word(NUM_CORES);

  always_comb begin
    case (region)
      RGN_CTL: word = {31'd0, ctl};
      RGN_CFG: word = CFG;
      RGN_PWR: word = pwr >> (8 * lane);
      default: word = 32'd0;
    endcase
  end

endmodule

// File: rtl/coh_ctrl_regs.sv
module coh_ctrl_regs
  import coh_regs_pkg::*;
#(
  parameter int unsigned NUM_CORES = 1,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [2:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid
);

  localparam int unsigned LANES = 4;

  initial begin
    if (NUM_CORES < 1 || NUM_CORES > 4) $error("NUM_CORES out of range 1..4");
  end

  region_t     region;
  logic [1:0]  lane;
  logic        wr_ok;
  logic        ctl_q;
  logic [31:0] pwr_q;
  logic [31:0] rd_word;

  coh_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr   (bus_addr),
    .region (region),
    .lane   (lane)
  );

  assign wr_ok = bus_req && bus_we && size_legal(bus_size);

  always_ff @(posedge clk) begin
    if (rst)                           ctl_q <= 1'b0;
    else if (wr_ok && region == RGN_CTL) ctl_q <= bus_wdata[0];
  end

  coh_pwr_bank #(.LANES(LANES)) u_pwr (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_ok && region == RGN_PWR),
    .lane   (lane),
    .size   (bus_size),
    .wdata  (bus_wdata),
    .status (pwr_q)
  );

  coh_rd_mux #(.NUM_CORES(NUM_CORES)) u_mux (
    .region (region),
    .lane   (lane),
    .ctl    (ctl_q),
    .pwr    (pwr_q),
    .word   (rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= 32'd0;
    end else begin
      bus_rvalid <= bus_req && !bus_we;
      if (bus_req && !bus_we) bus_rdata <= rd_word;
    end
  end

endmodule

// File: rtl/coh_ctrl_regs_chk.sv
module coh_ctrl_regs_chk
  import coh_regs_pkg::*;
#(
  parameter int unsigned NUM_CORES = 1,
  parameter int unsigned ADDR_W    = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [2:0]        bus_size,
  input logic [31:0]       bus_rdata,
  input logic              bus_rvalid,
  input logic              ctl_q,
  input logic [31:0]       pwr_q
);

  logic is_rd, is_hole;
  assign is_rd   = bus_req && !bus_we;
  assign is_hole = (bus_addr == ADDR_W'('h0C)) || (bus_addr == ADDR_W'('h40)) ||
                   (bus_addr == ADDR_W'('h44)) || (bus_addr == ADDR_W'('h50)) ||
                   (bus_addr == ADDR_W'('h54));

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!bus_rvalid && !ctl_q && pwr_q == 32'd0));

  p_ctl_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
    is_rd && bus_addr == ADDR_W'(0) |=> bus_rdata[31:1] == 31'd0);

  p_cfg_value_r3: assert property (@(posedge clk) disable iff (rst)
    is_rd && bus_addr == ADDR_W'(4) |=> bus_rdata == cfg_word(NUM_CORES));

  p_low_lanes_kept_r5: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_we && bus_addr == ADDR_W'('h0B) |=> $stable(pwr_q[23:0]));

  p_hole_raz_r7: assert property (@(posedge clk) disable iff (rst)
    is_rd && is_hole |=> bus_rdata == 32'd0);

  p_hole_wi_r7: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_we && is_hole |=> ($stable(pwr_q) && $stable(ctl_q)));

  p_bad_size_r8: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_we && !size_legal(bus_size) |=> ($stable(pwr_q) && $stable(ctl_q)));

  p_rvalid_on_read_r9: assert property (@(posedge clk) disable iff (rst)
    is_rd |=> bus_rvalid);

  p_rvalid_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !is_rd |=> !bus_rvalid);

endmodule

bind coh_ctrl_regs coh_ctrl_regs_chk #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_req    (bus_req),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_size   (bus_size),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .ctl_q      (ctl_q),
  .pwr_q      (pwr_q)
);

// File: tb/coh_ctrl_regs_test.sv
module coh_ctrl_regs_test;

  localparam int unsigned NUM_CORES = 1;
  localparam int unsigned ADDR_W    = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_req = 1'b0;
  logic              bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [2:0]        bus_size = 3'd4;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              bus_rvalid;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic        exp_ctl;
  logic [31:0] exp_pwr;

  always #10 clk = ~clk;

  coh_ctrl_regs #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [2:0] sz, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
    check("R9 no rvalid after write", {31'd0, bus_rvalid}, 32'd0);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a; bus_size = 3'd4;
    @(negedge clk);
    bus_req = 1'b0;
    check("R9 rvalid after read", {31'd0, bus_rvalid}, 32'd1);
    d = bus_rdata;
  endtask

  // bench model of a power-status write: lanes k..k+s-1, clipped at lane 3
  function automatic logic [31:0] pwr_model(input logic [31:0] old, input int k,
                                            input int s, input logic [31:0] d);
    logic [31:0] r = old;
    for (int j = 0; j < s; j++) begin
      if (k + j < 4) r[8*(k+j) +: 8] = d[8*j +: 8];
    end
    return r;
  endfunction

  function automatic logic [31:0] cfg_model();
    logic [31:0] r = 32'(NUM_CORES - 1);
    for (int i = 0; i < NUM_CORES; i++) r[4+i] = 1'b1;
    return r;
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    @(negedge clk);
    check("R1 rvalid low in reset", {31'd0, bus_rvalid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rvalid low after reset", {31'd0, bus_rvalid}, 32'd0);
    rd(8'h00, d); check("R1 enable cleared", d, 32'd0);
    rd(8'h08, d); check("R1 power word cleared", d, 32'd0);
    exp_ctl = 1'b0; exp_pwr = 32'd0;
  endtask

  task automatic t_ctl();
    logic [31:0] d;
    wr(8'h00, 3'd4, 32'hFFFF_FFFF); rd(8'h00, d); check("R2 bit0 set, upper zero", d, 32'd1);
    wr(8'h00, 3'd4, 32'hFFFF_FFFE); rd(8'h00, d); check("R2 bit0 cleared", d, 32'd0);
    wr(8'h00, 3'd1, 32'h0000_0081); rd(8'h00, d); check("R2 byte write", d, 32'd1);
    exp_ctl = 1'b1;
  endtask

  task automatic t_cfg();
    logic [31:0] d;
    rd(8'h04, d); check("R3 config word", d, cfg_model());
    wr(8'h04, 3'd4, 32'hFFFF_FFFF);
    rd(8'h04, d); check("R3 config read-only", d, cfg_model());
  endtask

  task automatic t_pwr_lanes();
    logic [31:0] d;
    wr(8'h08, 3'd4, 32'h1122_3344); exp_pwr = pwr_model(exp_pwr, 0, 4, 32'h1122_3344);
    rd(8'h08, d); check("R4 full word", d, exp_pwr);
    wr(8'h09, 3'd1, 32'hFFFF_FFAA); exp_pwr = pwr_model(exp_pwr, 1, 1, 32'hFFFF_FFAA);
    rd(8'h08, d); check("R4 byte at lane 1", d, exp_pwr);
    wr(8'h0A, 3'd2, 32'hFFFF_BBCC); exp_pwr = pwr_model(exp_pwr, 2, 2, 32'hFFFF_BBCC);
    rd(8'h08, d); check("R4 half at lane 2", d, exp_pwr);
    check("R4 model sanity", exp_pwr, 32'hBBCC_AA44);
  endtask

  task automatic t_pwr_read();
    logic [31:0] d;
    for (int k = 1; k < 4; k++) begin
      rd(8'(8 + k), d);
      check("R6 shifted read", d, exp_pwr >> (8 * k));
    end
  endtask

  task automatic t_clip();
    logic [31:0] d;
    wr(8'h0B, 3'd4, 32'hDEAD_BEEF); exp_pwr = pwr_model(exp_pwr, 3, 4, 32'hDEAD_BEEF);
    rd(8'h08, d); check("R5 word clipped at lane 3", d, exp_pwr);
    wr(8'h0A, 3'd4, 32'h5566_7788); exp_pwr = pwr_model(exp_pwr, 2, 4, 32'h5566_7788);
    rd(8'h08, d); check("R5 word clipped at lane 2", d, exp_pwr);
    wr(8'h0B, 3'd2, 32'h0000_1234); exp_pwr = pwr_model(exp_pwr, 3, 2, 32'h0000_1234);
    rd(8'h08, d); check("R5 half clipped", d, exp_pwr);
  endtask

  task automatic t_holes();
    logic [31:0] d;
    logic [7:0] holes [7] = '{8'h0C, 8'h40, 8'h44, 8'h50, 8'h54, 8'h01, 8'hFC};
    foreach (holes[i]) wr(holes[i], 3'd4, 32'hFFFF_FFFF);
    foreach (holes[i]) begin
      rd(holes[i], d); check("R7 hole reads zero", d, 32'd0);
    end
    wr(8'h0C, 3'd1, 32'h0000_0000);
    rd(8'h00, d); check("R7 enable untouched", d, {31'd0, exp_ctl});
    rd(8'h08, d); check("R7 power untouched", d, exp_pwr);
  endtask

  task automatic t_bad_size();
    logic [31:0] d;
    wr(8'h08, 3'd3, 32'h0000_0000);
    wr(8'h09, 3'd0, 32'h0000_0000);
    wr(8'h00, 3'd3, 32'h0000_0000);
    wr(8'h00, 3'd7, 32'h0000_0000);
    rd(8'h08, d); check("R8 power unchanged", d, exp_pwr);
    rd(8'h00, d); check("R8 enable unchanged", d, {31'd0, exp_ctl});
  endtask

  task automatic t_idle();
    @(negedge clk);
    @(negedge clk);
    check("R9 rvalid low when idle", {31'd0, bus_rvalid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_ctl();
    t_cfg();
    t_pwr_lanes();
    t_pwr_read();
    t_clip();
    t_holes();
    t_bad_size();
    t_idle();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule